// File: doc/BRIEF.md
# PWM Fault Shutdown Guard

This block sits between a PWM waveform generator and the output pins. It passes each PWM channel through unchanged until a fault occurs. Then it drives every channel to one common inactive level. Two things count as a fault: an active-low external fault input, and a debug breakpoint signal that software has allowed to act as a fault. The external fault input is asynchronous, so it passes through a synchronizer of at least two flops. Once the synchronized fault is seen, the outputs are forced inactive in the same cycle.

One 8-bit configuration/status register controls the block. The external fault can be switched on or off. Two recovery policies are available. In latched mode, the status bit stays set until software clears it. In cycle-by-cycle mode, the status bit clears by itself. In both modes, outputs come back only at a period-start strobe from the PWM timebase, so a partial pulse is never emitted. Software clears the status bit by writing 0 to it. That write is ignored while the synchronized fault is still present.

Top module: `pwm_fault_guard`

## Requirements
- R1: After reset, `cfg_rdata` reads 0x00 and `pwm_out` equals `pwm_in`.
- R2: Register layout. Bit 7 is the breakpoint-fault enable, bit 2 is the fault status, bit 1 is the mode (0 = latched, 1 = cycle-by-cycle) and bit 0 is the fault enable. Bits 6..3 always read 0. Writing 1 to bit 2 never sets the status.
- R3: With the fault enabled, a low level on `fault_n` drives every `pwm_out` bit to `IDLE_LVL`. This starts right after the second rising clock edge that sees the low level, and lasts for as long as the synchronized input stays low.
- R4: The status bit reads 1 one clock after the synchronized fault is first seen low, and stays 1 while the fault persists.
- R5: In latched mode, the status bit clears only when software writes 0 to bit 2 while the synchronized fault input is high. Such a write made while it is low is ignored.
- R6: In latched mode, outputs stay inactive after the fault input goes high. They resume at the first `period_start` that follows the status clear. A `period_start` that arrives while the status is still 1 has no effect.
- R7: In cycle-by-cycle mode, outputs stay inactive after the fault input goes high until the next `period_start`. At that clock edge, outputs resume and the status bit clears with no software action.
- R8: With bit 7 = 1, a high `brk` forces all outputs to `IDLE_LVL` in the same cycle and leaves the status bit unchanged. With bit 7 = 0, `brk` has no effect on the outputs.
- R9: With bit 0 = 0, `fault_n` is ignored: outputs follow `pwm_in` and the status reads 0. Clearing bit 0 during a shutdown clears the status one clock later and frees the outputs by two clocks later.
- R10: When a newly synchronized fault and a software write of 0 to the status bit meet at the same clock edge, the status bit ends at 1.
- R11: While no shutdown is in force, `pwm_out` follows every pattern on `pwm_in` within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data |
| period_start | input | 1 | One-cycle pulse at the start of each PWM period |
| fault_n | input | 1 | External fault, active low, asynchronous |
| brk | input | 1 | Debug breakpoint indication |
| pwm_in | input | N_CH | Channels from the PWM generator |
| pwm_out | output | N_CH | Guarded channels to the pins |

## Verification
Two events can land on the same clock edge: the status bit being set by a fault, and software clearing it. The bench times a register write of 0 so that it lands exactly on the first edge where the synchronized fault is low. At that point the status is already clear from an earlier software clear. The outcome is judged at the register: the status must read 1. A second pair that can coincide is a status clear and a `period_start`. The bench provokes it by pulsing `period_start` while the status is still set, and checks that the outputs stay inactive until a later period start.

// File: rtl/pfg_pkg.sv
`timescale 1ns/1ps
package pfg_pkg;
   localparam int CFG_W    = 8;
   localparam int BIT_BRK  = 7;
   localparam int BIT_STAT = 2;
   localparam int BIT_MODE = 1;
   localparam int BIT_EN   = 0;

   typedef struct packed {
      logic brk_en;
      logic cyc_mode;
      logic flt_en;
   } guard_cfg_t;
endpackage

// File: rtl/pfg_sync.sv
`timescale 1ns/1ps
module pfg_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/pfg_ctrl.sv
`timescale 1ns/1ps
module pfg_ctrl
   import pfg_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [CFG_W-1:0] wdata,
   output logic [CFG_W-1:0] rdata,
   input  logic             fault_sync_n,
   input  logic             period_start,
   input  logic             brk,
   output logic             blocked,
   output logic             force_idle
);
   guard_cfg_t cfg_q;
   logic       status_q;
   logic       status_nx;
   logic       blocked_nx;
   logic       fault_act;
   logic       sw_clr;
   logic       release_ok;

   assign fault_act = cfg_q.flt_en & ~fault_sync_n;
   assign sw_clr    = we & ~wdata[BIT_STAT];
   assign release_ok = cfg_q.cyc_mode ? 1'b1 : ~status_q;

   always_comb begin
      status_nx = status_q;
      if (!cfg_q.flt_en)               status_nx = 1'b0;
      else if (fault_act)              status_nx = 1'b1;
      else if (cfg_q.cyc_mode)         status_nx = (period_start && blocked) ? 1'b0 : status_q;
      else if (sw_clr)                 status_nx = 1'b0;
   end

   always_comb begin
      blocked_nx = blocked;
      if (!cfg_q.flt_en)                            blocked_nx = 1'b0;
      else if (fault_act)                           blocked_nx = 1'b1;
      else if (period_start && blocked && release_ok) blocked_nx = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q    <= '0;
         status_q <= 1'b0;
         blocked  <= 1'b0;
      end else begin
         if (we) begin
            cfg_q.brk_en   <= wdata[BIT_BRK];
            cfg_q.cyc_mode <= wdata[BIT_MODE];
            cfg_q.flt_en   <= wdata[BIT_EN];
         end
         status_q <= status_nx;
         blocked  <= blocked_nx;
      end
   end

   always_comb begin
      rdata           = '0;
      rdata[BIT_BRK]  = cfg_q.brk_en;
      rdata[BIT_STAT] = status_q;
      rdata[BIT_MODE] = cfg_q.cyc_mode;
      rdata[BIT_EN]   = cfg_q.flt_en;
   end

   assign force_idle = fault_act | blocked | (brk & cfg_q.brk_en);
endmodule

// File: rtl/pfg_gate.sv
`timescale 1ns/1ps
module pfg_gate #(
   parameter int   N_CH     = 6,
   parameter logic IDLE_LVL = 1'b0
) (
   input  logic            force_idle,
   input  logic [N_CH-1:0] pwm_in,
   output logic [N_CH-1:0] pwm_out
);
   for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
      assign pwm_out[ch] = force_idle ? IDLE_LVL : pwm_in[ch];
   end
endmodule

// File: rtl/pwm_fault_guard.sv
`timescale 1ns/1ps
module pwm_fault_guard
   import pfg_pkg::*;
#(
   parameter int   N_CH        = 6,
   parameter int   SYNC_STAGES = 2,
   parameter logic IDLE_LVL    = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [CFG_W-1:0] cfg_wdata,
   output logic [CFG_W-1:0] cfg_rdata,
   input  logic             period_start,
   input  logic             fault_n,
   input  logic             brk,
   input  logic [N_CH-1:0]  pwm_in,
   output logic [N_CH-1:0]  pwm_out
);
   if (N_CH < 1) begin : g_bad_nch
      $error("pwm_fault_guard: N_CH must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("pwm_fault_guard: SYNC_STAGES must be at least 2");
   end

   logic fault_sync_n;
   logic blocked;
   logic force_idle;

   pfg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (fault_n),
      .q     (fault_sync_n)
   );

   pfg_ctrl u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .we           (cfg_we),
      .wdata        (cfg_wdata),
      .rdata        (cfg_rdata),
      .fault_sync_n (fault_sync_n),
      .period_start (period_start),
      .brk          (brk),
      .blocked      (blocked),
      .force_idle   (force_idle)
   );

   pfg_gate #(.N_CH(N_CH), .IDLE_LVL(IDLE_LVL)) u_gate (
      .force_idle (force_idle),
      .pwm_in     (pwm_in),
      .pwm_out    (pwm_out)
   );
endmodule

// File: rtl/pfg_chk.sv
`timescale 1ns/1ps
module pfg_chk #(
   parameter int   N_CH     = 6,
   parameter logic IDLE_LVL = 1'b0
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cfg_we,
   input logic [7:0]      cfg_rdata,
   input logic            period_start,
   input logic            brk,
   input logic            fault_sync_n,
   input logic            blocked,
   input logic [N_CH-1:0] pwm_out
);
   localparam logic [N_CH-1:0] IDLE_VEC = {N_CH{IDLE_LVL}};

   AST_FAULT_FORCES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rdata[0] && !fault_sync_n) |-> (pwm_out == IDLE_VEC)); // R3
   AST_STATUS_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rdata[0] && !fault_sync_n) |=> cfg_rdata[2]); // R4
   AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rdata[0] && !cfg_rdata[1] && cfg_rdata[2] && !cfg_we) |=> cfg_rdata[2]); // R5
   AST_RELEASE_AT_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(blocked) |-> ($past(period_start) || !$past(cfg_rdata[0]))); // R6
   AST_CYCLE_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rdata[0] && cfg_rdata[1] && blocked && !period_start) |=> blocked); // R7
   AST_BRK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (brk && cfg_rdata[7]) |-> (pwm_out == IDLE_VEC)); // R8
   AST_DISABLED_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_rdata[0] |=> (!cfg_rdata[2] && !blocked)); // R9
endmodule

bind pwm_fault_guard pfg_chk #(.N_CH(N_CH), .IDLE_LVL(IDLE_LVL)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_we       (cfg_we),
   .cfg_rdata    (cfg_rdata),
   .period_start (period_start),
   .brk          (brk),
   .fault_sync_n (fault_sync_n),
   .blocked      (blocked),
   .pwm_out      (pwm_out)
);

// File: tb/tb_pwm_fault_guard.sv
`timescale 1ns/1ps
module tb_pwm_fault_guard;
   localparam int N = 6;
   localparam logic [N-1:0] IDLE = '0;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cfg_we = 1'b0;
   logic [7:0]   cfg_wdata = '0;
   logic [7:0]   cfg_rdata;
   logic         period_start = 1'b0;
   logic         fault_n = 1'b1;
   logic         brk = 1'b0;
   logic [N-1:0] pwm_in = 6'b101101;
   logic [N-1:0] pwm_out;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   pwm_fault_guard #(.N_CH(N)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .period_start(period_start), .fault_n(fault_n),
      .brk(brk), .pwm_in(pwm_in), .pwm_out(pwm_out)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step(int n = 1);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #2;
      end
   endtask

   task automatic wr(logic [7:0] v);
      cfg_we = 1'b1; cfg_wdata = v;
      step();
      cfg_we = 1'b0;
      #1;
   endtask

   task automatic pulse_period();
      period_start = 1'b1;
      step();
      period_start = 1'b0;
      #1;
   endtask

   task automatic t_reset();
      #1;
      check("R1 rdata after reset", cfg_rdata, 8'h00);
      check("R1 outputs after reset", pwm_out, pwm_in);
   endtask

   task automatic t_layout();
      wr(8'hFF);
      check("R2 reserved bits and status not settable", cfg_rdata, 8'h83);
      wr(8'h00);
      check("R2 all fields cleared", cfg_rdata, 8'h00);
   endtask

   task automatic t_passthru();
      wr(8'h01);
      pwm_in = 6'b000000; #1; check("R11 pattern 00", pwm_out, 6'b000000);
      pwm_in = 6'b111111; #1; check("R11 pattern 3f", pwm_out, 6'b111111);
      pwm_in = 6'b010110; #1; check("R11 pattern 16", pwm_out, 6'b010110);
      pwm_in = 6'b101101; #1;
   endtask

   task automatic t_cycle();
      wr(8'h03);
      fault_n = 1'b0;
      step(); #1;
      check("R3 not yet after one edge", pwm_out, pwm_in);
      step(); #1;
      check("R3 idle after second edge", pwm_out, IDLE);
      check("R4 status not yet", cfg_rdata[2], 1'b0);
      step(); #1;
      check("R4 status set", cfg_rdata[2], 1'b1);
      fault_n = 1'b1;
      step(4); #1;
      check("R7 held after fault removed", pwm_out, IDLE);
      check("R7 status still set", cfg_rdata[2], 1'b1);
      pulse_period();
      check("R7 outputs resume at period", pwm_out, pwm_in);
      check("R7 status auto clear", cfg_rdata[2], 1'b0);
   endtask

   task automatic t_latched();
      wr(8'h01);
      fault_n = 1'b0;
      step(3); #1;
      check("R4 status set latched", cfg_rdata[2], 1'b1);
      wr(8'h01);
      check("R5 clear ignored while fault low", cfg_rdata[2], 1'b1);
      fault_n = 1'b1;
      step(3); #1;
      check("R5 status held after fault removed", cfg_rdata[2], 1'b1);
      pulse_period();
      check("R6 period with status set ignored", pwm_out, IDLE);
      wr(8'h01);
      check("R5 software clear", cfg_rdata[2], 1'b0);
      check("R6 still idle before period", pwm_out, IDLE);
      step(2); #1;
      check("R6 still idle without period", pwm_out, IDLE);
      pulse_period();
      check("R6 resume at period after clear", pwm_out, pwm_in);
   endtask

   task automatic t_collision();
      wr(8'h01);
      fault_n = 1'b0;
      step(2);
      cfg_we = 1'b1; cfg_wdata = 8'h01;
      step();
      cfg_we = 1'b0; #1;
      check("R10 fault wins over clear", cfg_rdata[2], 1'b1);
      fault_n = 1'b1;
      step(3);
      wr(8'h01);
      pulse_period();
      check("R10 recovered", pwm_out, pwm_in);
   endtask

   task automatic t_brk();
      wr(8'h81);
      brk = 1'b1; #1;
      check("R8 breakpoint forces idle", pwm_out, IDLE);
      step(); #1;
      check("R8 status untouched", cfg_rdata[2], 1'b0);
      brk = 1'b0; #1;
      check("R8 released with brk low", pwm_out, pwm_in);
      wr(8'h01);
      brk = 1'b1; #1;
      check("R8 breakpoint ignored when disabled", pwm_out, pwm_in);
      brk = 1'b0; #1;
   endtask

   task automatic t_disable();
      wr(8'h00);
      fault_n = 1'b0;
      step(4); #1;
      check("R9 fault ignored outputs", pwm_out, pwm_in);
      check("R9 fault ignored status", cfg_rdata[2], 1'b0);
      fault_n = 1'b1;
      step(3);
      wr(8'h01);
      fault_n = 1'b0;
      step(3); #1;
      check("R9 shutdown before disable", pwm_out, IDLE);
      fault_n = 1'b1;
      step(3);
      wr(8'h00);
      step(); #1;
      check("R9 status cleared by disable", cfg_rdata[2], 1'b0);
      check("R9 outputs freed by disable", pwm_out, pwm_in);
   endtask

   initial begin
      step(3);
      rst_n = 1'b1;
      step();
      t_reset();
      t_layout();
      t_passthru();
      t_cycle();
      t_latched();
      t_collision();
      t_brk();
      t_disable();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule